// File: doc/BRIEF.md
# Banked Masked-Write Control Register File

This block holds the system-control registers of a small multithreaded core. A register is named by an 8-bit flat index equal to register*8 + select. On the `rd_idx` and `wr_idx` ports this is the 5-bit register number in bits [7:3] and the 3-bit select in bits [2:0]. Some registers are shared by the whole core. The machine status, thread status, thread binding and thread halt registers have one copy per hardware thread, picked by the context input `ctx`. The VPE control and VPE configuration registers have one copy per virtual processor (VPE). The VPE copy is picked by the VPE field of the binding register that belongs to `ctx`.

There are two write strobes. A masked write merges new data into the old value through a fixed writable mask for each register, so read-only fields keep their contents. A raw write is meant for privileged set-up. It stores the data as given and does not use the mask.

A masked write also asks for the per-thread run enables to be worked out again. A two-state machine does this one cycle after the write. In `ST_IDLE` nothing is pending. A masked write moves it to `ST_PEND`. While in `ST_PEND`, the machine latches, for every thread, the value Activated AND NOT Halt into `run_en`. It then goes back to `ST_IDLE`, unless another masked write comes in that same cycle, in which case it stays in `ST_PEND`.

Top module: `cpr_regfile`

## Requirements
- R1: The flat index is {register[4:0], select[2:0]}. Reading an index that holds no register returns 0. Writing such an index changes no register.
- R2: A masked write stores (wr_data & mask) | (old & ~mask). The masks are:
  - Status (0x60): 0xFF78FF17
  - Cause (0x68): 0x08C00300
  - EBase (0x79): 0x3FFFF000
  - IntCtl (0x61): 0x000003E0
  - SRSCtl (0x62): 0x0000F3C0
  - Index (0x00): 0x7FFFFFFF
  - thread status (0x11): all ones
  - thread halt (0x14): 0x00000001
  - VPE control (0x09): all ones
  - binding (0x12): only its VPE field, bits [VPE_W-1:0]
- R3: Masked writes leave these registers unchanged: PRId (0x78), Config1 (0x81), Config3 (0x83), LLAddr (0x88), MVP configuration (0x02) and VPE configuration (0x0A). All of them have mask 0.
- R4: A raw write stores wr_data unmasked. When both strobes are high, the raw write wins and the masked write is dropped. A raw write never schedules a run-enable update.
- R5: Status, thread status, binding and halt are banked per thread and addressed by `ctx`. When `ctx` >= NUM_TC, reads of these registers return 0 and writes to them are ignored.
- R6: VPE control and VPE configuration are banked per VPE. The bank is the binding VPE field of `ctx`. A field value >= NUM_VPE selects VPE 0.
- R7: Reset values are as follows:
  - Status: 0x00400004 (ERL bit 2 and BEV bit 22 set).
  - EBase: 0x80000000.
  - MVP configuration: bit 15 set, NUM_VPE-1 in bits [13:10], NUM_TC-1 in bits [7:0].
  - Thread status: thread 0 has Activated (bit 15) set; every other thread has bit 16 set.
  - Binding: each thread's own ID in bits [28:21].
  - VPE configuration: bit 1 set for VPE 0 only.
- R8: After an update, run_en[t] = thread-status bit 15 AND NOT halt bit 0 of thread t.
- R9: A masked write at clock edge E changes `run_en` at edge E+1, not before. A masked write made while an update is pending keeps it pending for one more evaluation.
- R10: Reads are combinational. A read of a location that is being written in the same cycle returns the old value.
- R11: After reset, `run_en` has only bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx | input | TC_W | Thread context selecting the banks for read and write |
| rd_idx | input | 8 | Read flat index {register, select} |
| rd_data | output | 32 | Combinational read data |
| wr_idx | input | 8 | Write flat index |
| wr_data | input | 32 | Write data |
| wr_msk_en | input | 1 | Masked write strobe; schedules a run update |
| wr_raw_en | input | 1 | Raw write strobe; ignores the mask |
| run_en | output | NUM_TC | Per-thread run enable |

## Verification
The bench builds the block with NUM_TC=3 and NUM_VPE=3. With these values the context input has a code (3) that names no thread, and the 2-bit VPE field can hold a value (3) that names no VPE. This makes it possible to check both fallback rules. The bench also sets non-default identity constants, so that the read-only registers can be told apart from reset zeros. With three threads, two updates issued back to back can be seen reaching different threads.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
    localparam int DW  = 32;
    localparam int NSH = 10;   // shared slots
    localparam int NTR = 4;    // per-thread slots
    localparam int NVR = 2;    // per-VPE slots

    typedef logic [7:0]    cpr_idx_t;
    typedef logic [DW-1:0] cpr_word_t;

    localparam cpr_idx_t IDX_INDEX  = 8'h00;
    localparam cpr_idx_t IDX_MVPCFG = 8'h02;
    localparam cpr_idx_t IDX_VPECTL = 8'h09;
    localparam cpr_idx_t IDX_VPECFG = 8'h0A;
    localparam cpr_idx_t IDX_TSTAT  = 8'h11;
    localparam cpr_idx_t IDX_TBIND  = 8'h12;
    localparam cpr_idx_t IDX_THALT  = 8'h14;
    localparam cpr_idx_t IDX_STATUS = 8'h60;
    localparam cpr_idx_t IDX_INTCTL = 8'h61;
    localparam cpr_idx_t IDX_SRSCTL = 8'h62;
    localparam cpr_idx_t IDX_CAUSE  = 8'h68;
    localparam cpr_idx_t IDX_PRID   = 8'h78;
    localparam cpr_idx_t IDX_EBASE  = 8'h79;
    localparam cpr_idx_t IDX_CFG1   = 8'h81;
    localparam cpr_idx_t IDX_CFG3   = 8'h83;
    localparam cpr_idx_t IDX_LLADDR = 8'h88;

    localparam int TSTAT_ACT   = 15;
    localparam int TSTAT_DYN   = 16;
    localparam int HALT_BIT    = 0;
    localparam int BIND_TC_LSB = 21;
    localparam int MVP_TCA     = 15;
    localparam int MVP_NV_LSB  = 10;
    localparam int PRID_SLOT   = 5;

    localparam cpr_word_t STATUS_RST = 32'h0040_0004;

    function automatic cpr_idx_t sh_idx(input int i);
        case (i)
            0: return IDX_INDEX;   1: return IDX_MVPCFG;
            2: return IDX_INTCTL;  3: return IDX_SRSCTL;
            4: return IDX_CAUSE;   5: return IDX_PRID;
            6: return IDX_EBASE;   7: return IDX_CFG1;
            8: return IDX_CFG3;    default: return IDX_LLADDR;
        endcase
    endfunction

    function automatic cpr_word_t sh_mask(input int i);
        case (i)
            0: return 32'h7FFF_FFFF;
            2: return 32'h0000_03E0;
            3: return 32'h0000_F3C0;
            4: return 32'h08C0_0300;
            6: return 32'h3FFF_F000;
            default: return '0;
        endcase
    endfunction

    function automatic cpr_word_t sh_rst(input int i, input cpr_word_t mvp,
                                         input cpr_word_t prid, input cpr_word_t cfg1,
                                         input cpr_word_t cfg3);
        case (i)
            1: return mvp;
            5: return prid;
            6: return 32'h8000_0000;
            7: return cfg1;
            8: return cfg3;
            default: return '0;
        endcase
    endfunction

    function automatic cpr_idx_t tr_idx(input int j);
        case (j)
            0: return IDX_STATUS;  1: return IDX_TSTAT;
            2: return IDX_TBIND;   default: return IDX_THALT;
        endcase
    endfunction

    function automatic cpr_word_t tr_mask(input int j, input int vpe_w);
        case (j)
            0: return 32'hFF78_FF17;
            1: return '1;
            2: return cpr_word_t'((64'd1 << vpe_w) - 64'd1);
            default: return cpr_word_t'(1) << HALT_BIT;
        endcase
    endfunction

    function automatic cpr_word_t tr_rst(input int j, input int t);
        case (j)
            0: return STATUS_RST;
            1: return (t == 0) ? (cpr_word_t'(1) << TSTAT_ACT) : (cpr_word_t'(1) << TSTAT_DYN);
            2: return cpr_word_t'(t) << BIND_TC_LSB;
            default: return '0;
        endcase
    endfunction

    function automatic cpr_idx_t vr_idx(input int k);
        return (k == 0) ? IDX_VPECTL : IDX_VPECFG;
    endfunction

    function automatic cpr_word_t vr_mask(input int k);
        return (k == 0) ? '1 : '0;
    endfunction

    function automatic cpr_word_t vr_rst(input int k, input int v);
        return (k == 1 && v == 0) ? 32'h0000_0002 : '0;
    endfunction
endpackage

// File: rtl/cpr_slot.sv
module cpr_slot
    import cpr_pkg::*;
#(
    parameter cpr_word_t MASK = '1,
    parameter cpr_word_t RST  = '0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_msk,
    input  logic      wr_raw,
    input  cpr_word_t wdata,
    output cpr_word_t q
);
    // raw beats masked; masked merges under the writable mask
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST;
        else if (wr_raw)
            q <= wdata;
        else if (wr_msk)
            q <= (wdata & MASK) | (q & ~MASK);
    end
endmodule

// File: rtl/cpr_run_fsm.sv
module cpr_run_fsm #(
    parameter int NUM_TC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_req,
    input  logic [NUM_TC-1:0] act,
    input  logic [NUM_TC-1:0] hlt,
    output logic [NUM_TC-1:0] run_en,
    output logic              pend
);
    localparam logic [NUM_TC-1:0] RUN_RST = NUM_TC'(1);

    typedef enum logic [0:0] {ST_IDLE, ST_PEND} upd_state_e;
    upd_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (upd_req) state_d = ST_PEND;
            ST_PEND: state_d = upd_req ? ST_PEND : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            run_en <= RUN_RST;
        else begin
            unique case (state_q)
                ST_PEND: run_en <= act & ~hlt;
                default: run_en <= run_en;
            endcase
        end
    end

    assign pend = (state_q == ST_PEND);
endmodule

// File: rtl/cpr_regfile.sv
module cpr_regfile
    import cpr_pkg::*;
#(
    parameter int        NUM_TC   = 4,
    parameter int        NUM_VPE  = 2,
    parameter cpr_word_t PRID_VAL = 32'h0001_9300,
    parameter cpr_word_t CFG1_VAL = 32'h9E19_0C8F,
    parameter cpr_word_t CFG3_VAL = 32'h0000_0020,
    localparam int       TC_W     = (NUM_TC > 1) ? $clog2(NUM_TC) : 1,
    localparam int       VPE_W    = (NUM_VPE > 1) ? $clog2(NUM_VPE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TC_W-1:0]   ctx,
    input  logic [7:0]        rd_idx,
    output logic [DW-1:0]     rd_data,
    input  logic [7:0]        wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              wr_msk_en,
    input  logic              wr_raw_en,
    output logic [NUM_TC-1:0] run_en
);
    localparam cpr_word_t MVP_RST = (cpr_word_t'(1) << MVP_TCA)
                                  | (cpr_word_t'(NUM_VPE - 1) << MVP_NV_LSB)
                                  | cpr_word_t'(NUM_TC - 1);

    cpr_word_t sh_q [NSH];
    cpr_word_t tr_q [NUM_TC][NTR];
    cpr_word_t vr_q [NUM_VPE][NVR];

    logic              raw_w, msk_w, ctx_ok, upd_pend;
    logic [TC_W-1:0]   ctx_sel;
    logic [VPE_W-1:0]  vfield, cur_vpe;
    logic [NUM_TC-1:0] act_vec, hlt_vec;

    assign raw_w   = wr_raw_en;
    assign msk_w   = wr_msk_en & ~wr_raw_en;
    assign ctx_ok  = (int'(ctx) < NUM_TC);
    assign ctx_sel = ctx_ok ? ctx : '0;
    assign vfield  = tr_q[ctx_sel][2][VPE_W-1:0];
    assign cur_vpe = (int'(vfield) < NUM_VPE) ? vfield : '0;

    for (genvar i = 0; i < NSH; i++) begin : g_sh
        logic hit;
        assign hit = (wr_idx == sh_idx(i));
        cpr_slot #(
            .MASK(sh_mask(i)),
            .RST (sh_rst(i, MVP_RST, PRID_VAL, CFG1_VAL, CFG3_VAL))
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_msk(msk_w & hit), .wr_raw(raw_w & hit),
            .wdata(wr_data), .q(sh_q[i])
        );
    end

    for (genvar t = 0; t < NUM_TC; t++) begin : g_tc
        for (genvar j = 0; j < NTR; j++) begin : g_reg
            logic hit;
            assign hit = ctx_ok && (ctx == TC_W'(t)) && (wr_idx == tr_idx(j));
            cpr_slot #(
                .MASK(tr_mask(j, VPE_W)),
                .RST (tr_rst(j, t))
            ) u_slot (
                .clk(clk), .rst_n(rst_n),
                .wr_msk(msk_w & hit), .wr_raw(raw_w & hit),
                .wdata(wr_data), .q(tr_q[t][j])
            );
        end
        assign act_vec[t] = tr_q[t][1][TSTAT_ACT];
        assign hlt_vec[t] = tr_q[t][3][HALT_BIT];
    end

    for (genvar v = 0; v < NUM_VPE; v++) begin : g_vpe
        for (genvar k = 0; k < NVR; k++) begin : g_reg
            logic hit;
            assign hit = ctx_ok && (cur_vpe == VPE_W'(v)) && (wr_idx == vr_idx(k));
            cpr_slot #(
                .MASK(vr_mask(k)),
                .RST (vr_rst(k, v))
            ) u_slot (
                .clk(clk), .rst_n(rst_n),
                .wr_msk(msk_w & hit), .wr_raw(raw_w & hit),
                .wdata(wr_data), .q(vr_q[v][k])
            );
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NSH; i++)
            if (rd_idx == sh_idx(i)) rd_data = sh_q[i];
        if (ctx_ok) begin
            for (int j = 0; j < NTR; j++)
                if (rd_idx == tr_idx(j)) rd_data = tr_q[ctx_sel][j];
            for (int k = 0; k < NVR; k++)
                if (rd_idx == vr_idx(k)) rd_data = vr_q[cur_vpe][k];
        end
    end

    cpr_run_fsm #(.NUM_TC(NUM_TC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .upd_req(msk_w),
        .act(act_vec), .hlt(hlt_vec), .run_en(run_en), .pend(upd_pend)
    );
endmodule

// File: rtl/cpr_regfile_chk.sv
module cpr_regfile_chk #(
    parameter int NUM_TC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_msk_en,
    input logic              wr_raw_en,
    input logic [7:0]        wr_idx,
    input logic              upd_pend,
    input logic [NUM_TC-1:0] run_en,
    input logic [NUM_TC-1:0] act,
    input logic [NUM_TC-1:0] hlt,
    input logic [31:0]       prid_q
);
    assert_run_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_pend |=> $stable(run_en));

    assert_sched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_msk_en && !wr_raw_en) |=> upd_pend);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pend && !(wr_msk_en && !wr_raw_en)) |=> !upd_pend);

    assert_raw_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_pend && wr_raw_en) |=> !upd_pend);

    assert_ro_prid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_msk_en && !wr_raw_en && wr_idx == 8'h78) |=> $stable(prid_q));

    assert_run_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pend |=> (run_en == $past(act & ~hlt)));
endmodule

bind cpr_regfile cpr_regfile_chk #(.NUM_TC(NUM_TC)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_msk_en(wr_msk_en), .wr_raw_en(wr_raw_en),
    .wr_idx(wr_idx), .upd_pend(upd_pend), .run_en(run_en),
    .act(act_vec), .hlt(hlt_vec), .prid_q(sh_q[5])
);

// File: tb/sim_cpr_regfile.sv
`timescale 1ns/1ps
module sim_cpr_regfile;
    localparam int NTC = 3;
    localparam int NVP = 3;
    localparam logic [31:0] PRID = 32'h0001_A5C3;
    localparam logic [31:0] CFG1 = 32'h9E19_0C8F;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  ctx = 0;
    logic [7:0]  rd_idx = 0, wr_idx = 0;
    logic [31:0] rd_data, wr_data = 0;
    logic        wr_msk_en = 0, wr_raw_en = 0;
    logic [NTC-1:0] run_en;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    cpr_regfile #(.NUM_TC(NTC), .NUM_VPE(NVP), .PRID_VAL(PRID), .CFG1_VAL(CFG1)) u0 (
        .clk(clk), .rst_n(rst_n), .ctx(ctx), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_msk_en(wr_msk_en),
        .wr_raw_en(wr_raw_en), .run_en(run_en)
    );

    // {op, ctx, req, idx, data, exp}; op 0 read, 1 masked, 2 raw
    localparam int NV = 20;
    localparam logic [79:0] TBL [NV] = '{
        {2'd1, 2'd0, 4'd2, 8'h60, 32'hFFFFFFFF, 32'hFF78FF17}, // R2 status
        {2'd1, 2'd0, 4'd2, 8'h60, 32'h00000000, 32'h00000000}, // R2
        {2'd1, 2'd1, 4'd5, 8'h60, 32'h12345678, 32'h12305610}, // R5 ctx1 bank
        {2'd0, 2'd0, 4'd5, 8'h60, 32'h00000000, 32'h00000000}, // R5 ctx0 untouched
        {2'd1, 2'd0, 4'd2, 8'h68, 32'hFFFFFFFF, 32'h08C00300}, // R2 cause
        {2'd2, 2'd0, 4'd4, 8'h68, 32'hDEADBEEF, 32'hDEADBEEF}, // R4 raw
        {2'd1, 2'd0, 4'd2, 8'h68, 32'h00000000, 32'hD62DBCEF}, // R2 keeps ro bits
        {2'd1, 2'd2, 4'd3, 8'h78, 32'h00000000, 32'h0001A5C3}, // R3 prid
        {2'd1, 2'd0, 4'd2, 8'h79, 32'hFFFFFFFF, 32'hBFFFF000}, // R2 ebase
        {2'd1, 2'd0, 4'd2, 8'h61, 32'hFFFFFFFF, 32'h000003E0}, // R2 intctl
        {2'd1, 2'd0, 4'd2, 8'h62, 32'hFFFFFFFF, 32'h0000F3C0}, // R2 srsctl
        {2'd1, 2'd0, 4'd2, 8'h00, 32'hFFFFFFFF, 32'h7FFFFFFF}, // R2 index
        {2'd0, 2'd0, 4'd7, 8'h02, 32'h00000000, 32'h00008802}, // R7 mvp cfg
        {2'd1, 2'd1, 4'd3, 8'h02, 32'h00000000, 32'h00008802}, // R3 mvp cfg
        {2'd1, 2'd0, 4'd3, 8'h81, 32'hFFFFFFFF, 32'h9E190C8F}, // R3 config1
        {2'd0, 2'd1, 4'd7, 8'h12, 32'h00000000, 32'h00200000}, // R7 bind
        {2'd0, 2'd2, 4'd7, 8'h11, 32'h00000000, 32'h00010000}, // R7 tstat dyn
        {2'd0, 2'd0, 4'd7, 8'h11, 32'h00000000, 32'h00008000}, // R7 tstat act
        {2'd1, 2'd0, 4'd1, 8'h05, 32'hFFFFFFFF, 32'h00000000}, // R1 hole
        {2'd1, 2'd0, 4'd3, 8'h88, 32'hFFFFFFFF, 32'h00000000}  // R3 lladdr
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int op, input logic [1:0] c, input logic [7:0] idx, input logic [31:0] d);
        @(negedge clk);
        ctx = c; wr_idx = idx; wr_data = d;
        wr_msk_en = (op == 1); wr_raw_en = (op == 2);
        @(negedge clk);
        wr_msk_en = 0; wr_raw_en = 0;
    endtask

    task automatic rd(input string tag, input logic [1:0] c, input logic [7:0] idx, input logic [31:0] exp);
        ctx = c; rd_idx = idx; #0.5;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 reset run_en", 32'(run_en), 32'h1);
        rd("R7 status reset", 0, 8'h60, 32'h00400004);
        rd("R7 ebase reset", 0, 8'h79, 32'h80000000);
        rd("R7 vpe cfg vpe0", 0, 8'h0A, 32'h2);

        for (int i = 0; i < NV; i++) begin
            logic [79:0] e;
            e = TBL[i];
            if (e[79:78] != 0) wr(int'(e[79:78]), e[77:76], e[71:64], e[63:32]);
            rd($sformatf("R%0d table entry %0d", e[75:72], i), e[77:76], e[71:64], e[31:0]);
        end
        repeat (2) @(negedge clk);

        // R6 per-VPE banking through the binding field
        wr(1, 0, 8'h09, 32'hAAAA5555);
        rd("R6 vpe0 ctl", 0, 8'h09, 32'hAAAA5555);
        wr(1, 1, 8'h12, 32'h1);
        rd("R6 bind vpe field", 1, 8'h12, 32'h00200001);
        rd("R6 vpe1 ctl empty", 1, 8'h09, 32'h0);
        rd("R6 vpe1 cfg", 1, 8'h0A, 32'h0);
        wr(1, 1, 8'h09, 32'h11111111);
        rd("R6 vpe0 untouched", 0, 8'h09, 32'hAAAA5555);
        wr(1, 2, 8'h12, 32'hFFFFFFFF);
        rd("R2 bind mask", 2, 8'h12, 32'h00400003);
        rd("R6 out-of-range vpe", 2, 8'h09, 32'hAAAA5555);
        rd("R5 ctx out of range", 3, 8'h60, 32'h0);
        wr(1, 3, 8'h60, 32'hFFFFFFFF);
        rd("R5 ctx3 write ignored", 0, 8'h60, 32'h0);
        repeat (2) @(negedge clk);

        // R8 / R9 deferred run update
        wr(1, 1, 8'h11, 32'h00008000);
        chk("R9 not yet", 32'(run_en), 32'h1);
        @(negedge clk);
        chk("R8 ctx1 runs", 32'(run_en), 32'h3);
        wr(1, 1, 8'h14, 32'h1);
        @(negedge clk);
        chk("R8 halt stops", 32'(run_en), 32'h1);
        wr(1, 1, 8'h14, 32'hFFFFFFFE);
        @(negedge clk);
        chk("R8 halt cleared", 32'(run_en), 32'h3);
        wr(2, 1, 8'h14, 32'h1);
        repeat (4) @(negedge clk);
        chk("R4 raw no update", 32'(run_en), 32'h3);
        rd("R4 raw halt stored", 1, 8'h14, 32'h1);
        wr(1, 0, 8'h05, 32'h0);
        @(negedge clk);
        chk("R9 later update", 32'(run_en), 32'h1);

        // R9 back-to-back writes
        @(negedge clk);
        ctx = 2; wr_idx = 8'h11; wr_data = 32'h00008000; wr_msk_en = 1;
        @(negedge clk);
        ctx = 1; wr_idx = 8'h14; wr_data = 32'h0;
        @(negedge clk);
        wr_msk_en = 0;
        chk("R9 first eval", 32'(run_en), 32'h5);
        @(negedge clk);
        chk("R9 second eval", 32'(run_en), 32'h7);

        // R10 read during write sees old value
        ctx = 0; rd_idx = 8'h68; wr_idx = 8'h68; wr_data = 32'hFFFFFFFF; wr_msk_en = 1;
        #0.5;
        chk("R10 old value", rd_data, 32'hD62DBCEF);
        @(negedge clk);
        wr_msk_en = 0;
        rd("R10 new value", 0, 8'h68, 32'hDEEDBFEF);

        // R4 raw wins over masked
        ctx = 0; wr_idx = 8'h00; wr_data = 32'h92345678; wr_msk_en = 1; wr_raw_en = 1;
        @(negedge clk);
        wr_msk_en = 0; wr_raw_en = 0;
        rd("R4 raw priority", 0, 8'h00, 32'h92345678);
        repeat (3) @(negedge clk);
        chk("R4 run stable", 32'(run_en), 32'h7);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule